// File: doc/BRIEF.md
# Four-Channel DMA Request Controller

This block is the front end of a four-channel DMA engine. It collects transfer requests for each channel and arbitrates among them. It then holds a grant on the winning channel until that channel's transfer ends. A request comes either from software, through a write to the global high control register, or from an active-low external request pin. The pin passes through a two-flop synchronizer and is sensed either by level or by falling edge. A channel takes part in arbitration only while its enable bit is set. The pending flags can be read back whether or not the channel is enabled.

The transfer engine loads each channel's transfer counter and pulses `step_i` once for every unit it moves on the granted channel. A transfer ends on the step that takes the counter to zero. A counter that already holds 0 also ends the transfer on its next step. When terminal-count signalling is enabled, the end of a transfer drives the shared open-drain terminal-count line low for one clock. The same line also works as an input: a falling level on it aborts the transfer in progress. The block's own low pulse is masked so that it does not abort the transfer granted right after it.

Channels 0 to 2 have an acknowledge output. It follows that channel's grant when the channel's acknowledge enable bit is set. Channel 3 has no acknowledge output.

Top module: `dma_req_ctrl`

## Requirements
- R1: Register address 0 (global low) holds the priority mode in bit 0 and the terminal-count enable in bit 1, and reads bits 7:4 as the pending-request flags of channels 3..0. Writes to bits 7:2 have no effect.
- R2: Register address 1 (global high): writing 1 to bit c (c = 0..3) raises a software request on channel c, and writing 0 leaves it unchanged. Bits 7:4 are the channel enables. The register reads back as {enables, software requests}. Every register resets to 0.
- R3: A channel is granted only while its enable bit is 1. Its pending flag is shown whether or not the channel is enabled.
- R4: Register address 2+c holds channel c's configuration in bits 5:0 and reads bits 7:6 as 0. Bits 3:0 select the source, and only the value 0001 lets the pin raise a request. Bit 4 selects edge sensing when 1 and level sensing when 0. Bit 5 enables the acknowledge output.
- R5: Each request pin passes through two flops. In level mode the channel requests while the synchronized pin is low. In edge mode a falling edge of the synchronized pin latches a request, and the grant clears it.
- R6: In priority mode 0, the lowest-numbered eligible channel wins.
- R7: In priority mode 1, the search starts at the channel after the last one granted and wraps around.
- R8: A grant is registered one clock after the request becomes eligible, with at most one grant bit high. The grant holds until the transfer ends or is cancelled, and no new grant is made in that cycle. The grant clears the channel's software request.
- R9: For channels 0 to 2, `ack_o[c]` is high exactly while channel c is granted and its acknowledge enable is set.
- R10: While a channel is granted, `step_i` decrements its counter (stopping at 0), and the step taken at a count of 1 or 0 ends the transfer. `cnt_load_i` loads channel `cnt_ch_i`, and a load takes precedence over a step. When terminal count is enabled, `tc_oe_o` is high for exactly the one cycle after the ending step.
- R11: When terminal count is enabled, a synchronized falling edge on `tc_i` ends the active transfer and clears that channel's latched requests. A falling edge caused by the block's own `tc_oe_o` pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address (0 low, 1 high, 2..5 channel config) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| xreq_ni | input | 4 | Active-low external request pins |
| grant_o | output | 4 | One-hot grant of the active channel |
| ack_o | output | 3 | Acknowledge for channels 0..2 |
| cnt_load_i | input | 1 | Load strobe for a transfer counter |
| cnt_ch_i | input | 2 | Channel selected for load and for cnt_o |
| cnt_val_i | input | 16 | Counter load value |
| cnt_o | output | 16 | Counter of channel cnt_ch_i |
| step_i | input | 1 | One unit transferred on the granted channel |
| tc_oe_o | output | 1 | Pull-down enable for the terminal-count line |
| tc_i | input | 1 | Level sensed on the terminal-count line |

## Verification
The hardest case to reach is the block's own terminal-count pulse. That low pulse comes back through the synchronizer two clocks later, while a second channel, queued behind the first, has just been granted. If the pulse were not masked, the block would abort its own next transfer. The stimulus sets this up by queueing two software requests with terminal count enabled: a count of 1 on the winner and a longer count on the runner-up. The bench models the line as a wired AND of the bench's own drive and `tc_oe_o`, so the reflection occurs naturally. A later external low level on the line then confirms that a genuine falling edge still cancels the transfer.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  localparam int unsigned NCH  = 4;
  localparam int unsigned CH_W = $clog2(NCH);

  localparam logic [2:0] A_GLO = 3'd0;
  localparam logic [2:0] A_GHI = 3'd1;
  localparam logic [2:0] A_CH0 = 3'd2;

  localparam logic [3:0] SRC_PIN = 4'b0001;

  typedef struct packed {
    logic       ack_en;
    logic       edge_mode;
    logic [3:0] src;
  } ch_cfg_t;
endpackage

// File: rtl/dma_sync.sv
module dma_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
      s3_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign q_o    = s2_q;
  assign fall_o = s3_q & ~s2_q;
endmodule

// File: rtl/dma_chan_req.sv
module dma_chan_req
  import dma_req_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ch_cfg_t cfg_i,
  input  logic    pin_i,      // synchronized, active low
  input  logic    pin_fall_i,
  input  logic    sw_set_i,
  input  logic    clr_i,
  output logic    sw_o,
  output logic    req_o
);
  logic sw_q, lat_q;
  logic pin_sel;

  assign pin_sel = (cfg_i.src == SRC_PIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q  <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      if (sw_set_i)  sw_q <= 1'b1;
      else if (clr_i) sw_q <= 1'b0;
      if (pin_fall_i && pin_sel && cfg_i.edge_mode) lat_q <= 1'b1;
      else if (clr_i)                                lat_q <= 1'b0;
    end
  end

  assign sw_o  = sw_q;
  assign req_o = sw_q | (pin_sel & (cfg_i.edge_mode ? lat_q : ~pin_i));
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  req_i,
  input  logic          rr_i,
  input  logic [IW-1:0] last_i,
  output logic [IW-1:0] win_o,
  output logic          any_o
);
  always_comb begin
    win_o = '0;
    any_o = 1'b0;
    for (int k = 0; k < int'(N); k++) begin
      int idx;
      idx = rr_i ? ((int'(last_i) + 1 + k) % int'(N)) : k;
      if (!any_o && req_i[idx]) begin
        any_o = 1'b1;
        win_o = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_req_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned NACK  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  input  logic [NCH-1:0]   xreq_ni,
  output logic [NCH-1:0]   grant_o,
  output logic [NACK-1:0]  ack_o,
  input  logic             cnt_load_i,
  input  logic [CH_W-1:0]  cnt_ch_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  output logic [CNT_W-1:0] cnt_o,
  input  logic             step_i,
  output logic             tc_oe_o,
  input  logic             tc_i
);
  logic             prio_q, tcen_q, active_q;
  logic [NCH-1:0]   en_q, sw_q, raw_req, clr, pin_s, pin_fall;
  logic [CH_W-1:0]  ach_q, last_q, win;
  logic             any_elig, grant_fire, done, cancel;
  logic             tc_s, tc_fall, oe_d1_q, oe_d2_q, tc_oe_q;
  ch_cfg_t          cfg_q [NCH];
  logic [CNT_W-1:0] cnt_q [NCH];
  logic             we_lo, we_hi;

  assign we_lo = reg_we_i && reg_addr_i == A_GLO;
  assign we_hi = reg_we_i && reg_addr_i == A_GHI;

  dma_sync #(.W(NCH)) u_pin_sync (
    .clk_i, .rst_ni, .d_i(xreq_ni), .q_o(pin_s), .fall_o(pin_fall)
  );

  dma_sync #(.W(1)) u_tc_sync (
    .clk_i, .rst_ni, .d_i(tc_i), .q_o(tc_s), .fall_o(tc_fall)
  );

  dma_arb #(.N(NCH), .IW(CH_W)) u_arb (
    .req_i(raw_req & en_q), .rr_i(prio_q), .last_i(last_q),
    .win_o(win), .any_o(any_elig)
  );

  assign grant_fire = !active_q && any_elig;
  assign done       = active_q && step_i && (cnt_q[ach_q] <= CNT_W'(1));
  // mask the reflection of our own pulse through the synchronizer
  assign cancel     = tcen_q && tc_fall && !(tc_oe_q || oe_d1_q || oe_d2_q);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign clr[c] = (grant_fire && win == CH_W'(c)) ||
                    (cancel && active_q && ach_q == CH_W'(c));

    dma_chan_req u_req (
      .clk_i, .rst_ni,
      .cfg_i(cfg_q[c]), .pin_i(pin_s[c]), .pin_fall_i(pin_fall[c]),
      .sw_set_i(we_hi && reg_wdata_i[c]), .clr_i(clr[c]),
      .sw_o(sw_q[c]), .req_o(raw_req[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[c] <= '0;
      else if (reg_we_i && reg_addr_i == A_CH0 + 3'(c))
        cfg_q[c] <= ch_cfg_t'(reg_wdata_i[5:0]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q[c] <= '0;
      else if (cnt_load_i && cnt_ch_i == CH_W'(c)) cnt_q[c] <= cnt_val_i;
      else if (active_q && ach_q == CH_W'(c) && step_i && cnt_q[c] != '0)
        cnt_q[c] <= cnt_q[c] - 1'b1;
    end

    assign grant_o[c] = active_q && ach_q == CH_W'(c);
  end

  for (genvar c = 0; c < NACK; c++) begin : g_ack
    assign ack_o[c] = grant_o[c] && cfg_q[c].ack_en;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q   <= 1'b0;
      tcen_q   <= 1'b0;
      en_q     <= '0;
      active_q <= 1'b0;
      ach_q    <= '0;
      last_q   <= '0;
      tc_oe_q  <= 1'b0;
      oe_d1_q  <= 1'b0;
      oe_d2_q  <= 1'b0;
    end else begin
      if (we_lo) begin
        prio_q <= reg_wdata_i[0];
        tcen_q <= reg_wdata_i[1];
      end
      if (we_hi) en_q <= reg_wdata_i[7:4];
      if (grant_fire) begin
        active_q <= 1'b1;
        ach_q    <= win;
        last_q   <= win;
      end else if (done || cancel) begin
        active_q <= 1'b0;
      end
      tc_oe_q <= done && tcen_q;
      oe_d1_q <= tc_oe_q;
      oe_d2_q <= oe_d1_q;
    end
  end

  assign tc_oe_o = tc_oe_q;
  assign cnt_o   = cnt_q[cnt_ch_i];

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_GLO) reg_rdata_o = {raw_req, 2'b00, tcen_q, prio_q};
    else if (reg_addr_i == A_GHI) reg_rdata_o = {en_q, sw_q};
    else begin
      for (int c = 0; c < int'(NCH); c++)
        if (reg_addr_i == A_CH0 + 3'(c)) reg_rdata_o = {2'b00, cfg_q[c]};
    end
  end
endmodule

// File: rtl/dma_req_ctrl_chk.sv
module dma_req_ctrl_chk #(
  parameter int unsigned NCH  = 4,
  parameter int unsigned NACK = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NCH-1:0]  grant_o,
  input logic [NACK-1:0] ack_o,
  input logic            tc_oe_o,
  input logic [NCH-1:0]  en_q
);
  // R8
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  // R9
  ack_needs_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o & ~grant_o[NACK-1:0]) == '0);

  // R10
  tc_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_oe_o |=> !tc_oe_o);

  // R10
  tc_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_oe_o |-> ($past(|grant_o) && !(|grant_o)));

  // R3
  grant_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~$past(grant_o) & ~$past(en_q)) == '0);
endmodule

bind dma_req_ctrl dma_req_ctrl_chk #(.NCH(dma_req_pkg::NCH), .NACK(NACK)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .grant_o(grant_o), .ack_o(ack_o),
  .tc_oe_o(tc_oe_o), .en_q(en_q)
);

// File: tb/tb_dma_req_ctrl.sv
module tb_dma_req_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wd = '0;
  logic [3:0] pin_n = '1;
  logic load = 1'b0, step = 1'b0, tc_ext = 1'b1;
  logic [1:0] lch = '0;
  logic [15:0] lval = '0;
  logic [7:0] rd;
  logic [3:0] grant;
  logic [2:0] ack;
  logic [15:0] cnt;
  logic tc_oe;
  wire tc_line = tc_ext & ~tc_oe;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  dma_req_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wd), .reg_rdata_o(rd), .xreq_ni(pin_n), .grant_o(grant),
    .ack_o(ack), .cnt_load_i(load), .cnt_ch_i(lch), .cnt_val_i(lval),
    .cnt_o(cnt), .step_i(step), .tc_oe_o(tc_oe), .tc_i(tc_line)
  );

  // behavioural reference
  logic [3:0] p1, p2, p3, m_sw, m_lat, m_en;
  logic [5:0] m_cfg [4];
  logic m_prio, m_tcen, m_act, m_oe, m_oe1, m_oe2, t1, t2, t3;
  int m_ach, m_last;
  int m_cnt [4];

  function automatic logic [3:0] m_raw();
    logic [3:0] r;
    for (int c = 0; c < 4; c++)
      r[c] = m_sw[c] | ((m_cfg[c][3:0] == 4'b0001) &&
             (m_cfg[c][4] ? m_lat[c] : !p2[c]));
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 = '1; p2 = '1; p3 = '1; t1 = 1; t2 = 1; t3 = 1;
      m_sw = 0; m_lat = 0; m_en = 0; m_prio = 0; m_tcen = 0; m_act = 0;
      m_oe = 0; m_oe1 = 0; m_oe2 = 0; m_ach = 0; m_last = 0;
      for (int c = 0; c < 4; c++) begin m_cfg[c] = 0; m_cnt[c] = 0; end
    end else begin : mdl
      logic [3:0] elig, pfall, ns, nl;
      logic fire, cancel, done, found;
      int win;
      elig = m_raw() & m_en;
      found = 0; win = 0;
      for (int k = 0; k < 4; k++) begin
        int idx;
        idx = m_prio ? (m_last + 1 + k) % 4 : k;
        if (!found && elig[idx]) begin found = 1; win = idx; end
      end
      fire = !m_act && found;
      cancel = m_tcen && t3 && !t2 && !(m_oe || m_oe1 || m_oe2);
      done = m_act && step && m_cnt[m_ach] <= 1;
      pfall = p3 & ~p2;
      for (int c = 0; c < 4; c++) begin
        logic clr;
        clr = (fire && win == c) || (cancel && m_act && m_ach == c);
        ns[c] = clr ? 1'b0 : m_sw[c];
        if (we && addr == 1 && wd[c]) ns[c] = 1;
        nl[c] = clr ? 1'b0 : m_lat[c];
        if (pfall[c] && m_cfg[c][3:0] == 4'b0001 && m_cfg[c][4]) nl[c] = 1;
        if (load && lch == c) m_cnt[c] = lval;
        else if (m_act && m_ach == c && step && m_cnt[c] != 0) m_cnt[c]--;
        if (we && addr == 3'(2 + c)) m_cfg[c] = wd[5:0];
      end
      m_sw = ns; m_lat = nl;
      if (we && addr == 0) begin m_prio = wd[0]; m_tcen = wd[1]; end
      if (we && addr == 1) m_en = wd[7:4];
      t3 = t2; t2 = t1; t1 = tc_ext & ~m_oe;
      m_oe2 = m_oe1; m_oe1 = m_oe; m_oe = done && m_tcen;
      if (fire) begin m_act = 1; m_ach = win; m_last = win; end
      else if (done || cancel) m_act = 0;
      p3 = p2; p2 = p1; p1 = pin_n;
    end
  end

  task automatic check(string tag, logic [31:0] a, logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, a, e);
    end
  endtask

  function automatic logic [7:0] exp_rd();
    case (addr)
      3'd0: return {m_raw(), 2'b00, m_tcen, m_prio};
      3'd1: return {m_en, m_sw};
      3'd2, 3'd3, 3'd4, 3'd5: return {2'b00, m_cfg[addr - 2]};
      default: return 8'h00;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin : cmp
      logic [3:0] eg;
      eg = m_act ? (4'b1 << m_ach) : 4'b0;
      check("R8 grant", grant, eg);
      check("R9 ack", ack, eg[2:0] & {m_cfg[2][5], m_cfg[1][5], m_cfg[0][5]});
      check("R10 tc_oe", tc_oe, m_oe);
      check("R10 cnt", cnt, 16'(m_cnt[lch]));
      check("R1 rdata", rd, exp_rd());
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(posedge clk); #1 we = 1; addr = a; wd = d;
    @(posedge clk); #1 we = 0;
  endtask
  task automatic ld(logic [1:0] c, logic [15:0] v);
    @(posedge clk); #1 load = 1; lch = c; lval = v;
    @(posedge clk); #1 load = 0;
  endtask
  task automatic stp();
    @(posedge clk); #1 step = 1;
    @(posedge clk); #1 step = 0;
  endtask
  task automatic wn(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic at_pos();
    @(posedge clk); #1;
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #23 rst_n = 1;
    at_pos(); addr = 1;
    @(negedge clk);
    check("R2 reset high reg", rd, 8'h00);
    check("R8 reset grant", grant, 4'h0);
    // R1: upper bits of the low register are not writable
    wr(0, 8'hF1); @(negedge clk);
    check("R1 low reg readback", rd, 8'h01);
    wr(0, 8'h00);
    // R2/R3: software request while disabled
    ld(0, 3);
    wr(1, 8'h01); addr = 0; @(negedge clk);
    check("R3 pending while disabled", rd, 8'h10);
    wn(3); check("R3 no grant when disabled", grant, 4'h0);
    wr(1, 8'h10); addr = 1; wn(2);
    check("R8 grant ch0", grant, 4'h1);
    check("R2 sw request cleared at grant", rd, 8'h10);
    stp(); stp(); wn(1); check("R10 still active", grant, 4'h1);
    stp(); wn(1); check("R10 ends at zero", grant, 4'h0);
    // R6 fixed priority
    ld(1, 1); ld(2, 1); ld(3, 1);
    wr(1, 8'hFE); wn(2); check("R6 fixed first", grant, 4'h2);
    stp(); wn(2); check("R6 fixed second", grant, 4'h4);
    stp(); wn(2); check("R6 fixed third", grant, 4'h8);
    stp(); wn(2); check("R6 idle", grant, 4'h0);
    // R7 round robin
    wr(0, 8'h01);
    wr(1, 8'hF2); wn(2); check("R7 single", grant, 4'h2);
    stp(); wr(1, 8'hF5); wn(2); check("R7 after last", grant, 4'h4);
    stp(); wn(2); check("R7 wrap", grant, 4'h1);
    stp(); wn(2);
    // R5/R9 level pin with acknowledge
    wr(4, 8'h21); at_pos(); pin_n[2] = 0; wn(5);
    check("R5 level grant", grant, 4'h4);
    check("R9 ack ch2", ack, 3'b100);
    at_pos(); pin_n[2] = 1; wn(4); stp(); wn(2);
    check("R5 level released", grant, 4'h0);
    // R4 non-pin source ignores the pin
    wr(4, 8'h02); addr = 0; at_pos(); pin_n[2] = 0; wn(5);
    check("R4 pin ignored", rd[7:4], 4'h0);
    check("R4 no grant", grant, 4'h0);
    at_pos(); pin_n[2] = 1; wn(3);
    // R5 edge latch, R3 pending shown while disabled
    wr(1, 8'hD0); wr(3, 8'h11); addr = 0;
    at_pos(); pin_n[1] = 0; at_pos(); pin_n[1] = 1; wn(5);
    check("R5 edge latched", rd[7:4], 4'h2);
    check("R3 edge no grant", grant, 4'h0);
    wr(1, 8'hF0); addr = 0; wn(2);
    check("R5 edge grant", grant, 4'h2);
    check("R5 latch cleared", rd[7:4], 4'h0);
    stp(); wn(2);
    // R10/R11 terminal count pulse and cancel
    wr(0, 8'h02); ld(0, 1); ld(1, 5);
    wr(1, 8'hF3); wn(2); check("R10 grant ch0", grant, 4'h1);
    stp(); @(negedge clk); check("R10 tc pulse", tc_oe, 1'b1);
    @(negedge clk); check("R10 tc one cycle", tc_oe, 1'b0);
    wn(6); check("R11 own pulse ignored", grant, 4'h2);
    at_pos(); tc_ext = 0; wn(5);
    check("R11 external cancel", grant, 4'h0);
    at_pos(); tc_ext = 1; wn(4);
    check("R11 stays idle", grant, 4'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule